// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a set of interrupt source lines and the processors' interrupt controllers. Each pin owns a 64-bit redirection entry that chooses a polarity, an edge or level trigger, a mask, a delivery mode, a destination and a vector. Source events arrive one at a time as (source index, level) pairs. The block keeps a pending bit for every pin and a remote-acknowledge flag for level pins. It turns the lowest-numbered eligible pin into a delivery message on a valid/ready output.

When an entry selects the external-interrupt delivery mode, the vector comes from a legacy controller through a request/acknowledge fetch. An end-of-interrupt input carries a vector and releases level pins that wait on that vector. Entries are loaded through a plain whole-entry write port. The engine is the only owner of the remote-acknowledge flag.

Top module: `irq_redir_engine`

## Requirements
- R1: After reset every entry is masked (entry bit 16 set), no pin is pending, and msg_valid and vf_req are low. An active edge on any source then produces no message.
- R2: The effective level of a source event is src_lvl XOR the entry's polarity bit 13. With bit 13 set, a low input is active and a high input is inactive.
- R3: For a level pin (entry bit 15 = 1), an active level sets pending and an inactive level clears it, whether or not the pin is masked. A level pin that goes pending while masked is delivered once it is unmasked.
- R4: For an edge pin (bit 15 = 0), an active event sets pending only if the mask bit 16 is clear. An event on a masked edge pin is lost and is not delivered after a later unmask. Delivery clears the pending bit, so one event gives one message.
- R5: Source index 0 drives pin 2. Source k for 1 <= k < NPINS drives pin k. Source indices at or above NPINS have no effect.
- R6: Among the pins that are pending, unmasked and not waiting for remote acknowledge, the lowest pin index is delivered first.
- R7: A message carries destination = entry bits 63:56, destination mode = bit 11, delivery mode = bits 10:8, trigger = bit 15, and vector = bits 7:0.
- R8: When the delivery mode is 7, vf_req is raised and held until vf_ack. The message vector is then vf_vec, and msg_valid is never high together with vf_req.
- R9: Delivering a level pin sets its remote-acknowledge flag. The pin is not delivered again until an end-of-interrupt carrying the vector in its entry bits 7:0 clears that flag. An end-of-interrupt with another vector has no effect. If the pin is still pending after the flag clears, it is delivered again.
- R10: While msg_valid is high and msg_ready is low, msg_valid and all message fields hold. Only one message is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one redirection entry |
| cfg_pin | input | PINW | Pin index of the entry to write (indices >= NPINS ignored) |
| cfg_entry | input | 64 | Entry value; bit 14 and bit 12 are ignored |
| src_vld | input | 1 | Source event strobe |
| src_id | input | SRCW | Source index of the event |
| src_lvl | input | 1 | Raw input level of the event |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector acknowledged by the end-of-interrupt |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv | output | 3 | Delivery mode code |
| msg_vec | output | 8 | Vector |
| msg_trig | output | 1 | Trigger mode, 1 = level |
| vf_req | output | 1 | Vector fetch request to the legacy controller |
| vf_ack | input | 1 | Vector fetch acknowledge |
| vf_vec | input | 8 | Fetched vector, valid with vf_ack |

## Verification
The hardest state to reach from the ports is several pins pending at the same time, which is what shows the ascending-order rule. A single event is normally delivered about two cycles after it arrives. The bench therefore raises one pin and holds msg_ready low, so the engine is stalled with a message out. While it is stalled, the bench raises two lower pins in reverse order, then releases the stall and checks the order in which they come out. The remote-acknowledge hold is reached in a similar way: a level pin is left active after its delivery, and the bench sends a non-matching end-of-interrupt and then a matching one.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  // Entry field positions (decoded by neighbours, so fixed)
  localparam int F_VEC_LSB  = 0;
  localparam int F_DM_LSB   = 8;
  localparam int F_DSTM_BIT = 11;
  localparam int F_POL_BIT  = 13;
  localparam int F_TRIG_BIT = 15;
  localparam int F_MASK_BIT = 16;
  localparam int F_DEST_LSB = 56;

  localparam logic [2:0] DM_EXTINT = 3'd7;

  // Route fields kept in inferred RAM
  typedef struct packed {
    logic [7:0] dest;
    logic       dmode;
    logic [2:0] dm;
  } route_t;

  typedef enum logic [1:0] {SC_PICK, SC_LOAD, SC_FETCH, SC_SEND} sc_state_e;
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int PINW = $clog2(NPINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [PINW-1:0]       wpin,
  input  logic [63:0]           wentry,
  input  logic [PINW-1:0]       rd_pin,
  output logic [NPINS-1:0]      mask_o,
  output logic [NPINS-1:0]      trig_o,
  output logic [NPINS-1:0]      pol_o,
  output logic [NPINS-1:0][7:0] vec_o,
  output route_t                route_q
);
  route_t route_ram [NPINS];
  logic   wr_ok;
  logic   unused_bits;

  assign wr_ok       = we && (32'(wpin) < NPINS);
  assign unused_bits = ^{wentry[55:17], wentry[14], wentry[12]};

  // Per-pin control bits and vectors in flops: scanned in parallel
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '1;
      trig_o <= '0;
      pol_o  <= '0;
      vec_o  <= '0;
    end else if (wr_ok) begin
      mask_o[wpin] <= wentry[F_MASK_BIT];
      trig_o[wpin] <= wentry[F_TRIG_BIT];
      pol_o[wpin]  <= wentry[F_POL_BIT];
      vec_o[wpin]  <= wentry[F_VEC_LSB +: 8];
    end
  end

  // Route fields only needed for the chosen pin: RAM with registered read
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      route_ram[wpin] <= '{dest:  wentry[F_DEST_LSB +: 8],
                           dmode: wentry[F_DSTM_BIT],
                           dm:    wentry[F_DM_LSB +: 3]};
    end
    route_q <= route_ram[rd_pin];
  end
endmodule

// File: rtl/irq_redir_state.sv
module irq_redir_state #(
  parameter int NPINS = 24,
  localparam int PINW = $clog2(NPINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_vld,
  input  logic [PINW-1:0]       ev_pin,
  input  logic                  ev_lvl,
  input  logic [NPINS-1:0]      mask,
  input  logic [NPINS-1:0]      trig,
  input  logic [NPINS-1:0]      pol,
  input  logic [NPINS-1:0][7:0] vec,
  input  logic                  eoi_vld,
  input  logic [7:0]            eoi_vec,
  input  logic                  svc_vld,
  input  logic [PINW-1:0]       svc_pin,
  output logic [NPINS-1:0]      pend,
  output logic [NPINS-1:0]      rirr
);
  logic [NPINS-1:0] pend_d, rirr_d;

  always_comb begin
    pend_d = pend;
    rirr_d = rirr;
    for (int i = 0; i < NPINS; i++) begin
      // delivery side: edge drops pending, level latches remote flag
      if (svc_vld && svc_pin == PINW'(i)) begin
        if (trig[i]) rirr_d[i] = 1'b1;
        else         pend_d[i] = 1'b0;
      end
      // end-of-interrupt matched by vector
      if (eoi_vld && rirr[i] && vec[i] == eoi_vec) rirr_d[i] = 1'b0;
      // source event after delivery so a fresh edge is kept
      if (ev_vld && ev_pin == PINW'(i)) begin
        if (trig[i])                              pend_d[i] = ev_lvl ^ pol[i];
        else if ((ev_lvl ^ pol[i]) && !mask[i])   pend_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      rirr <= '0;
    end else begin
      pend <= pend_d;
      rirr <= rirr_d;
    end
  end

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_chk
    AST_MASKED_EDGE_DROP: assert property (@(posedge clk) disable iff (rst)
      (ev_vld && ev_pin == PINW'(gi) && !trig[gi] && mask[gi] && !pend[gi]) |=> !pend[gi])
      else $error("masked edge set pending"); // R4
    AST_LEVEL_INACTIVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (ev_vld && ev_pin == PINW'(gi) && trig[gi] && !(ev_lvl ^ pol[gi])) |=> !pend[gi])
      else $error("inactive level left pending"); // R3
    AST_RIRR_EOI_ONLY: assert property (@(posedge clk) disable iff (rst)
      $fell(rirr[gi]) |-> $past(eoi_vld))
      else $error("remote flag cleared without EOI"); // R9
  end
endmodule

// File: rtl/irq_redir_sched.sv
module irq_redir_sched
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int PINW = $clog2(NPINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPINS-1:0]      pend,
  input  logic [NPINS-1:0]      mask,
  input  logic [NPINS-1:0]      rirr,
  input  logic [NPINS-1:0]      trig,
  input  logic [NPINS-1:0][7:0] vec,
  input  route_t                route_q,
  output logic [PINW-1:0]       rd_pin,
  output logic                  svc_vld,
  output logic [PINW-1:0]       svc_pin,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [7:0]            msg_dest,
  output logic                  msg_dest_mode,
  output logic [2:0]            msg_deliv,
  output logic [7:0]            msg_vec,
  output logic                  msg_trig,
  output logic                  vf_req,
  input  logic                  vf_ack,
  input  logic [7:0]            vf_vec
);
  sc_state_e        st;
  logic [PINW-1:0]  cur_pin;
  logic [NPINS-1:0] elig;
  logic [PINW-1:0]  pick;
  logic             any;

  assign elig = pend & ~mask & ~rirr;
  assign any  = |elig;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (elig[i]) pick = PINW'(i);
    end
  end

  assign rd_pin  = pick;
  assign svc_vld = (st == SC_LOAD);
  assign svc_pin = cur_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= SC_PICK;
      cur_pin       <= '0;
      msg_valid     <= 1'b0;
      msg_dest      <= '0;
      msg_dest_mode <= 1'b0;
      msg_deliv     <= '0;
      msg_vec       <= '0;
      msg_trig      <= 1'b0;
      vf_req        <= 1'b0;
    end else begin
      case (st)
        SC_PICK: begin
          if (any) begin
            cur_pin <= pick;
            st      <= SC_LOAD;
          end
        end
        SC_LOAD: begin
          msg_dest      <= route_q.dest;
          msg_dest_mode <= route_q.dmode;
          msg_deliv     <= route_q.dm;
          msg_trig      <= trig[cur_pin];
          if (route_q.dm == DM_EXTINT) begin
            vf_req <= 1'b1;
            st     <= SC_FETCH;
          end else begin
            msg_vec   <= vec[cur_pin];
            msg_valid <= 1'b1;
            st        <= SC_SEND;
          end
        end
        SC_FETCH: begin
          if (vf_ack) begin
            msg_vec   <= vf_vec;
            vf_req    <= 1'b0;
            msg_valid <= 1'b1;
            st        <= SC_SEND;
          end
        end
        SC_SEND: begin
          if (msg_ready) begin
            msg_valid <= 1'b0;
            st        <= SC_PICK;
          end
        end
        default: st <= SC_PICK;
      endcase
    end
  end

  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec) && $stable(msg_dest) && $stable(msg_deliv)))
    else $error("message changed while stalled"); // R10
  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
    (vf_req && !vf_ack) |=> (vf_req && !msg_valid))
    else $error("fetch request dropped"); // R8
  AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vf_req && msg_valid))
    else $error("fetch and message together"); // R8
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!msg_valid && !vf_req))
    else $error("outputs active after reset"); // R1
endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int SRCW  = 5,
  localparam int PINW = $clog2(NPINS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [PINW-1:0] cfg_pin,
  input  logic [63:0]     cfg_entry,
  input  logic            src_vld,
  input  logic [SRCW-1:0] src_id,
  input  logic            src_lvl,
  input  logic            eoi_vld,
  input  logic [7:0]      eoi_vec,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [7:0]      msg_dest,
  output logic            msg_dest_mode,
  output logic [2:0]      msg_deliv,
  output logic [7:0]      msg_vec,
  output logic            msg_trig,
  output logic            vf_req,
  input  logic            vf_ack,
  input  logic [7:0]      vf_vec
);
  logic [NPINS-1:0]      mask, trig, pol, pend, rirr;
  logic [NPINS-1:0][7:0] vec;
  route_t                route_q;
  logic [PINW-1:0]       rd_pin, svc_pin, ev_pin;
  logic                  svc_vld, ev_vld;

  // source 0 goes to pin 2, out-of-range sources dropped
  always_comb begin
    ev_vld = src_vld && (32'(src_id) < NPINS);
    ev_pin = (src_id == '0) ? PINW'(2) : PINW'(src_id);
  end

  irq_redir_table #(.NPINS(NPINS)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .wpin(cfg_pin), .wentry(cfg_entry),
    .rd_pin(rd_pin), .mask_o(mask), .trig_o(trig), .pol_o(pol),
    .vec_o(vec), .route_q(route_q)
  );

  irq_redir_state #(.NPINS(NPINS)) u_state (
    .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev_pin(ev_pin), .ev_lvl(src_lvl),
    .mask(mask), .trig(trig), .pol(pol), .vec(vec),
    .eoi_vld(eoi_vld), .eoi_vec(eoi_vec),
    .svc_vld(svc_vld), .svc_pin(svc_pin), .pend(pend), .rirr(rirr)
  );

  irq_redir_sched #(.NPINS(NPINS)) u_sched (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask), .rirr(rirr), .trig(trig),
    .vec(vec), .route_q(route_q), .rd_pin(rd_pin),
    .svc_vld(svc_vld), .svc_pin(svc_pin),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_vec(msg_vec),
    .msg_trig(msg_trig), .vf_req(vf_req), .vf_ack(vf_ack), .vf_vec(vf_vec)
  );
endmodule

// File: tb/irq_redir_engine_tb.sv
module irq_redir_engine_tb_top;
  localparam int NPINS = 24;
  localparam int SRCW  = 5;
  localparam int PINW  = $clog2(NPINS);
  localparam logic [7:0] FETCH_VEC = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [PINW-1:0] cfg_pin = '0;
  logic [63:0] cfg_entry = '0;
  logic src_vld = 1'b0;
  logic [SRCW-1:0] src_id = '0;
  logic src_lvl = 1'b0;
  logic eoi_vld = 1'b0;
  logic [7:0] eoi_vec = '0;
  logic msg_valid, msg_dest_mode, msg_trig, vf_req;
  logic msg_ready = 1'b0;
  logic [7:0] msg_dest, msg_vec;
  logic [2:0] msg_deliv;
  logic vf_ack = 1'b0;
  logic [7:0] vf_vec = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_redir_engine #(.NPINS(NPINS), .SRCW(SRCW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_entry(cfg_entry),
    .src_vld(src_vld), .src_id(src_id), .src_lvl(src_lvl),
    .eoi_vld(eoi_vld), .eoi_vec(eoi_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_vec(msg_vec),
    .msg_trig(msg_trig), .vf_req(vf_req), .vf_ack(vf_ack), .vf_vec(vf_vec)
  );

  typedef struct packed {
    logic [4:0] src;
    logic       pol;
    logic       trig;
    logic       msk;
    logic [2:0] dm;
    logic       dmode;
    logic [7:0] vec;
    logic [7:0] dest;
    logic       lvl;
    logic       exp;
    logic [3:0] req;
  } vrow_t;

  localparam vrow_t VT [10] = '{
    '{5'd3,  1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h31, 8'h05, 1'b1, 1'b1, 4'd4}, // R4 edge delivered
    '{5'd0,  1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h40, 8'h11, 1'b1, 1'b1, 4'd5}, // R5 source 0 to pin 2
    '{5'd4,  1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 8'h42, 8'h00, 1'b1, 1'b0, 4'd4}, // R4 masked edge lost
    '{5'd5,  1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'h50, 8'h22, 1'b0, 1'b1, 4'd2}, // R2 active-low level
    '{5'd6,  1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h51, 8'h00, 1'b0, 1'b0, 4'd3}, // R3 inactive level
    '{5'd7,  1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h52, 8'h00, 1'b1, 1'b0, 4'd2}, // R2 inverted edge idle
    '{5'd8,  1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 8'h60, 8'h33, 1'b1, 1'b1, 4'd8}, // R8 fetched vector
    '{5'd9,  1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 8'h61, 8'h44, 1'b1, 1'b1, 4'd7}, // R7 fields, level
    '{5'd30, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h62, 8'h00, 1'b1, 1'b0, 4'd5}, // R5 out of range
    '{5'd1,  1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'hFE, 8'hFF, 1'b1, 1'b1, 4'd7}  // R7 fields, edge
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic pol, input logic trig, input logic msk,
                                      input logic [2:0] dm, input logic dmode,
                                      input logic [7:0] vec, input logic [7:0] dest);
    logic [63:0] e;
    e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmode; e[13] = pol;
    e[15] = trig; e[16] = msk; e[63:56] = dest;
    return e;
  endfunction

  task automatic put(input int pin, input logic [63:0] e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = PINW'(pin); cfg_entry = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic evt(input int src, input logic lvl);
    @(negedge clk);
    src_vld = 1'b1; src_id = SRCW'(src); src_lvl = lvl;
    @(negedge clk);
    src_vld = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_vld = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi_vld = 1'b0;
  endtask

  // waits for a message, answering vector fetches on the way
  task automatic wait_msg(output logic got, output logic fetched, input int lim);
    got = 1'b0; fetched = 1'b0;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (vf_req && !vf_ack) begin
        vf_ack = 1'b1; vf_vec = FETCH_VEC; fetched = 1'b1;
      end else begin
        vf_ack = 1'b0;
      end
      if (msg_valid) begin
        got = 1'b1;
        break;
      end
    end
    vf_ack = 1'b0;
  endtask

  task automatic ack_msg();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic got, fch;
    logic [7:0] ev;
    int pin;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: quiet after reset, entries masked
    chk(!msg_valid, "R1 msg_valid", 32'(msg_valid), 0);
    chk(!vf_req, "R1 vf_req", 32'(vf_req), 0);
    evt(3, 1'b1);
    wait_msg(got, fch, 12);
    chk(!got, "R1 masked at reset", 32'(got), 0);

    // table walk
    for (int k = 0; k < 10; k++) begin
      pin = (VT[k].src == 0) ? 2 : int'(VT[k].src);
      put(pin, mk(VT[k].pol, VT[k].trig, VT[k].msk, VT[k].dm, VT[k].dmode, VT[k].vec, VT[k].dest));
      evt(int'(VT[k].src), VT[k].lvl);
      wait_msg(got, fch, 12);
      chk(got == VT[k].exp, $sformatf("R%0d row %0d delivered", VT[k].req, k), 32'(got), 32'(VT[k].exp));
      if (got) begin
        ev = (VT[k].dm == 3'd7) ? FETCH_VEC : VT[k].vec;
        chk(msg_vec == ev, $sformatf("R%0d row %0d vector", VT[k].req, k), 32'(msg_vec), 32'(ev));
        chk(msg_dest == VT[k].dest, $sformatf("R%0d row %0d dest", VT[k].req, k), 32'(msg_dest), 32'(VT[k].dest));
        chk(msg_deliv == VT[k].dm && msg_dest_mode == VT[k].dmode && msg_trig == VT[k].trig,
            $sformatf("R%0d row %0d mode fields", VT[k].req, k),
            {27'(0), msg_deliv, msg_dest_mode, msg_trig}, {27'(0), VT[k].dm, VT[k].dmode, VT[k].trig});
        chk(fch == (VT[k].dm == 3'd7), "R8 fetch used", 32'(fch), 32'(VT[k].dm == 3'd7));
        ack_msg();
      end
      evt(int'(VT[k].src), VT[k].pol);
      eoi(VT[k].vec);
      put(pin, mk(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00));
    end

    // R9: remote flag holds a level pin until matching EOI
    put(10, mk(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h70, 8'h01));
    evt(10, 1'b1);
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h70, "R9 first level delivery", 32'(msg_vec), 32'h70);
    ack_msg();
    wait_msg(got, fch, 12);
    chk(!got, "R9 no redelivery before EOI", 32'(got), 0);
    eoi(8'h71);
    wait_msg(got, fch, 12);
    chk(!got, "R9 wrong-vector EOI ignored", 32'(got), 0);
    eoi(8'h70);
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h70, "R9 redelivery after EOI", 32'(got), 1);
    if (got) ack_msg();
    evt(10, 1'b0);
    eoi(8'h70);
    put(10, mk(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00));

    // R6 and R10: stall with one message out, then two lower pins pend
    put(20, mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h80, 8'h02));
    put(12, mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h82, 8'h02));
    put(11, mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h81, 8'h02));
    evt(20, 1'b1);
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h80, "R6 first pin out", 32'(msg_vec), 32'h80);
    evt(12, 1'b1);
    evt(11, 1'b1);
    repeat (4) @(negedge clk);
    chk(msg_valid && msg_vec == 8'h80, "R10 held while stalled", 32'(msg_vec), 32'h80);
    ack_msg();
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h81, "R6 lowest pin first", 32'(msg_vec), 32'h81);
    ack_msg();
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h82, "R6 next pin", 32'(msg_vec), 32'h82);
    ack_msg();
    for (int p = 11; p <= 20; p++) put(p, mk(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00));

    // R4: masked edge lost across unmask, one event one message
    put(13, mk(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 8'h90, 8'h03));
    evt(13, 1'b1);
    put(13, mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h90, 8'h03));
    wait_msg(got, fch, 12);
    chk(!got, "R4 masked edge not replayed", 32'(got), 0);
    evt(13, 1'b1);
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h90, "R4 unmasked edge", 32'(got), 1);
    if (got) ack_msg();
    wait_msg(got, fch, 12);
    chk(!got, "R4 single delivery per edge", 32'(got), 0);
    put(13, mk(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00));

    // R3: masked level pending survives, inactive level clears
    put(15, mk(1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 8'h92, 8'h04));
    evt(15, 1'b1);
    evt(15, 1'b0);
    put(15, mk(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h92, 8'h04));
    wait_msg(got, fch, 12);
    chk(!got, "R3 cleared level stays quiet", 32'(got), 0);
    put(14, mk(1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 8'h91, 8'h04));
    evt(14, 1'b1);
    wait_msg(got, fch, 12);
    chk(!got, "R3 masked level held", 32'(got), 0);
    put(14, mk(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h91, 8'h04));
    wait_msg(got, fch, 12);
    chk(got && msg_vec == 8'h91, "R3 delivered on unmask", 32'(got), 1);
    if (got) ack_msg();
    evt(14, 1'b0);
    eoi(8'h91);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule